// File: doc/BRIEF.md
# Bufferless Deflection Torus Router

This block is one router tile of a two-dimensional torus in which every link runs in one direction only: packets travel east along a row and north along a column, and the wrap-around wiring joins the last column back to the first and the last row back to the first. Each cycle the tile may receive one packet from its west neighbour, one from its south neighbour and one from the local client. It hands each packet to the east output, the north output or the local exit, all within that cycle.

The tile has no packet storage. Routing follows dimension order: a packet moves east until its x coordinate matches the tile, then north until its y coordinate matches, and then leaves on the local exit. When two packets want the same output, the losing one is deflected onto a free network output and keeps moving. It is never held back. Packets already in the network rank above the client, so the client sees a ready signal that tells it whether its injection would be accepted this cycle. Deflection can change the order in which packets arrive, and endpoints must accept that.

Top module: `deflect_torus_router`

## Requirements
- R1: After reset, the east, north and exit valid outputs are all low.
- R2: An output reflects the packets presented in the previous cycle. A cycle with no input packets gives all valid outputs low in the next cycle.
- R3: The preferred output is east when the x destination differs from the tile's x coordinate. It is north when x matches and y differs. It is the local exit when both match.
- R4: The destination coordinates are compared only for equality. A destination whose coordinate is numerically below the tile's still takes the east (or north) link and reaches it by wrap-around.
- R5: A packet from the west input always leaves on its preferred output.
- R6: A south packet whose preferred output is taken by the west packet is deflected. It goes east if the west packet took north or the exit, and north if the west packet took east. With no conflict it takes its preferred output.
- R7: Every valid west or south packet leaves on exactly one output in the next cycle with its payload intact. No network packet is dropped.
- R8: The injection-ready output is high exactly when the local packet's preferred output is not claimed by a west or south packet. An accepted local packet leaves on that output in the next cycle.
- R9: A local packet offered while injection-ready is low has no effect: it appears on no output.
- R10: A packet whose destination equals the tile's coordinates raises the exit valid strobe for one cycle and presents its payload on the exit port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| w_vld | input | 1 | West input packet valid |
| w_dx | input | CW | West input x destination |
| w_dy | input | CW | West input y destination |
| w_pay | input | PW | West input payload |
| s_vld | input | 1 | South input packet valid |
| s_dx | input | CW | South input x destination |
| s_dy | input | CW | South input y destination |
| s_pay | input | PW | South input payload |
| l_vld | input | 1 | Local injection valid |
| l_dx | input | CW | Local injection x destination |
| l_dy | input | CW | Local injection y destination |
| l_pay | input | PW | Local injection payload |
| l_rdy | output | 1 | Local injection accepted this cycle |
| e_vld | output | 1 | East output valid |
| e_dx | output | CW | East output x destination |
| e_dy | output | CW | East output y destination |
| e_pay | output | PW | East output payload |
| n_vld | output | 1 | North output valid |
| n_dx | output | CW | North output x destination |
| n_dy | output | CW | North output y destination |
| n_pay | output | PW | North output payload |
| x_vld | output | 1 | Local exit strobe |
| x_pay | output | PW | Local exit payload |

## Verification
The assertions check on every cycle that the number of packets leaving matches the number accepted one cycle earlier, that a west packet lands on its preferred output with its payload, and that a south packet in conflict with a west packet is deflected to the correct free link. They also check that the ready signal drops whenever the client's output is claimed. Only the bench scenarios can show the coordinate behaviour of a particular tile: wrap-around destinations below the tile's own coordinates, and the exact choice among east, north and exit for each destination. They also cover the combined cases where all three inputs are active, and confirm that a refused local packet appears on no output.

// File: rtl/deflect_torus_router.sv
module deflect_torus_router #(
  parameter int K    = 4,
  parameter int MY_X = 1,
  parameter int MY_Y = 2,
  parameter int PW   = 8,
  localparam int CW  = (K > 1) ? $clog2(K) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          w_vld,
  input  logic [CW-1:0] w_dx,
  input  logic [CW-1:0] w_dy,
  input  logic [PW-1:0] w_pay,
  input  logic          s_vld,
  input  logic [CW-1:0] s_dx,
  input  logic [CW-1:0] s_dy,
  input  logic [PW-1:0] s_pay,
  input  logic          l_vld,
  input  logic [CW-1:0] l_dx,
  input  logic [CW-1:0] l_dy,
  input  logic [PW-1:0] l_pay,
  output logic          l_rdy,
  output logic          e_vld,
  output logic [CW-1:0] e_dx,
  output logic [CW-1:0] e_dy,
  output logic [PW-1:0] e_pay,
  output logic          n_vld,
  output logic [CW-1:0] n_dx,
  output logic [CW-1:0] n_dy,
  output logic [PW-1:0] n_pay,
  output logic          x_vld,
  output logic [PW-1:0] x_pay
);

  typedef enum logic [1:0] {D_E = 2'd0, D_N = 2'd1, D_L = 2'd2} dir_t;

  localparam logic [CW-1:0] HX = CW'(MY_X);
  localparam logic [CW-1:0] HY = CW'(MY_Y);

  function automatic dir_t pref(input logic [CW-1:0] dx, input logic [CW-1:0] dy);
    if (dx != HX)      return D_E;
    else if (dy != HY) return D_N;
    else               return D_L;
  endfunction

  dir_t w_d, s_d, s_fin, l_d;
  logic clm_e, clm_n, clm_l, l_go;

  assign w_d   = pref(w_dx, w_dy);
  assign s_d   = pref(s_dx, s_dy);
  assign l_d   = pref(l_dx, l_dy);
  assign s_fin = (!w_vld || s_d != w_d) ? s_d : ((w_d != D_E) ? D_E : D_N);

  assign clm_e = (w_vld && w_d == D_E) || (s_vld && s_fin == D_E);
  assign clm_n = (w_vld && w_d == D_N) || (s_vld && s_fin == D_N);
  assign clm_l = (w_vld && w_d == D_L) || (s_vld && s_fin == D_L);

  assign l_rdy = (l_d == D_E) ? !clm_e : (l_d == D_N) ? !clm_n : !clm_l;
  assign l_go  = l_vld && l_rdy;

  logic          ne_v, nn_v, nx_v;
  logic [CW-1:0] ne_x, ne_y, nn_x, nn_y;
  logic [PW-1:0] ne_p, nn_p, nx_p;

  always_comb begin
    ne_v = 1'b0; ne_x = '0; ne_y = '0; ne_p = '0;
    nn_v = 1'b0; nn_x = '0; nn_y = '0; nn_p = '0;
    nx_v = 1'b0; nx_p = '0;
    if (l_go) begin
      case (l_d)
        D_E:     begin ne_v = 1'b1; ne_x = l_dx; ne_y = l_dy; ne_p = l_pay; end
        D_N:     begin nn_v = 1'b1; nn_x = l_dx; nn_y = l_dy; nn_p = l_pay; end
        default: begin nx_v = 1'b1; nx_p = l_pay; end
      endcase
    end
    if (s_vld) begin
      case (s_fin)
        D_E:     begin ne_v = 1'b1; ne_x = s_dx; ne_y = s_dy; ne_p = s_pay; end
        D_N:     begin nn_v = 1'b1; nn_x = s_dx; nn_y = s_dy; nn_p = s_pay; end
        default: begin nx_v = 1'b1; nx_p = s_pay; end
      endcase
    end
    if (w_vld) begin
      case (w_d)
        D_E:     begin ne_v = 1'b1; ne_x = w_dx; ne_y = w_dy; ne_p = w_pay; end
        D_N:     begin nn_v = 1'b1; nn_x = w_dx; nn_y = w_dy; nn_p = w_pay; end
        default: begin nx_v = 1'b1; nx_p = w_pay; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld <= 1'b0; n_vld <= 1'b0; x_vld <= 1'b0;
      e_dx <= '0; e_dy <= '0; e_pay <= '0;
      n_dx <= '0; n_dy <= '0; n_pay <= '0;
      x_pay <= '0;
    end else begin
      e_vld <= ne_v; e_dx <= ne_x; e_dy <= ne_y; e_pay <= ne_p;
      n_vld <= nn_v; n_dx <= nn_x; n_dy <= nn_y; n_pay <= nn_p;
      x_vld <= nx_v; x_pay <= nx_p;
    end
  end

  a_r7_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |->
      $countones({e_vld, n_vld, x_vld}) ==
      $countones({$past(w_vld), $past(s_vld), $past(l_vld && l_rdy)}));

  a_r5_west_east: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(w_vld && w_dx != HX)) |-> (e_vld && e_pay == $past(w_pay)));

  a_r10_west_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(w_vld && w_dx == HX && w_dy == HY)) |-> (x_vld && x_pay == $past(w_pay)));

  a_r6_south_defl_north: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(w_vld && s_vld && w_dx != HX && s_dx != HX))
      |-> (n_vld && n_pay == $past(s_pay)));

  a_r8_block_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (w_vld && w_dx != HX && l_dx != HX) |-> !l_rdy);

endmodule

// File: tb/sim_deflect_torus_router.sv
module sim_deflect_torus_router;
  localparam int K = 4, PW = 8, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic w_vld = 0, s_vld = 0, l_vld = 0;
  logic [CW-1:0] w_dx = 0, w_dy = 0, s_dx = 0, s_dy = 0, l_dx = 0, l_dy = 0;
  logic [PW-1:0] w_pay = 0, s_pay = 0, l_pay = 0;
  logic l_rdy, e_vld, n_vld, x_vld;
  logic [CW-1:0] e_dx, e_dy, n_dx, n_dy;
  logic [PW-1:0] e_pay, n_pay, x_pay;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  deflect_torus_router #(.K(K), .MY_X(1), .MY_Y(2), .PW(PW)) u0 (
    .clk, .rst_n, .w_vld, .w_dx, .w_dy, .w_pay, .s_vld, .s_dx, .s_dy, .s_pay,
    .l_vld, .l_dx, .l_dy, .l_pay, .l_rdy, .e_vld, .e_dx, .e_dy, .e_pay,
    .n_vld, .n_dx, .n_dy, .n_pay, .x_vld, .x_pay);

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic wv, int wx, int wy, int wp, logic sv, int sx, int sy, int sp,
                       logic lv, int lx, int ly, int lp);
    w_vld = wv; w_dx = CW'(wx); w_dy = CW'(wy); w_pay = PW'(wp);
    s_vld = sv; s_dx = CW'(sx); s_dy = CW'(sy); s_pay = PW'(sp);
    l_vld = lv; l_dx = CW'(lx); l_dy = CW'(ly); l_pay = PW'(lp);
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
    drive(0,0,0,0, 0,0,0,0, 0,0,0,0);
  endtask

  task automatic outs(string req, logic ev, int ep, logic nv, int np, logic xv, int xp);
    chk(req, "e_vld", e_vld, ev); if (ev) chk(req, "e_pay", e_pay, ep);
    chk(req, "n_vld", n_vld, nv); if (nv) chk(req, "n_pay", n_pay, np);
    chk(req, "x_vld", x_vld, xv); if (xv) chk(req, "x_pay", x_pay, xp);
  endtask

  task automatic t_reset;
    outs("R1", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_dim_order;
    drive(1,3,0,8'h11, 0,0,0,0, 0,0,0,0); step;
    outs("R3", 1, 8'h11, 0, 0, 0, 0);
    chk("R3", "e_dx", e_dx, 3);
    drive(1,1,0,8'h12, 0,0,0,0, 0,0,0,0); step;
    outs("R3", 0, 0, 1, 8'h12, 0, 0);
    drive(1,1,2,8'h13, 0,0,0,0, 0,0,0,0); step;
    outs("R10", 0, 0, 0, 0, 1, 8'h13);
    step;
    outs("R2", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_wrap;
    drive(1,0,2,8'h21, 0,0,0,0, 0,0,0,0); step;
    outs("R4", 1, 8'h21, 0, 0, 0, 0);
    drive(0,0,0,0, 1,1,1,8'h22, 0,0,0,0); step;
    outs("R4", 0, 0, 1, 8'h22, 0, 0);
  endtask

  task automatic t_contention;
    drive(1,3,0,8'h31, 1,2,3,8'h32, 0,0,0,0); step;
    outs("R6", 1, 8'h31, 1, 8'h32, 0, 0);
    drive(1,1,3,8'h33, 1,1,0,8'h34, 0,0,0,0); step;
    outs("R5", 1, 8'h34, 1, 8'h33, 0, 0);
    drive(1,1,2,8'h35, 1,1,2,8'h36, 0,0,0,0); step;
    outs("R7", 1, 8'h36, 0, 0, 1, 8'h35);
    drive(0,0,0,0, 1,1,2,8'h37, 0,0,0,0); step;
    outs("R6", 0, 0, 0, 0, 1, 8'h37);
  endtask

  task automatic t_inject;
    drive(0,0,0,0, 0,0,0,0, 1,3,3,8'h41); #1;
    chk("R8", "l_rdy", l_rdy, 1); step;
    outs("R8", 1, 8'h41, 0, 0, 0, 0);
    drive(1,2,0,8'h42, 0,0,0,0, 1,0,0,8'h43); #1;
    chk("R8", "l_rdy", l_rdy, 0); step;
    outs("R9", 1, 8'h42, 0, 0, 0, 0);
    drive(1,3,1,8'h44, 1,0,1,8'h45, 1,1,2,8'h46); #1;
    chk("R8", "l_rdy", l_rdy, 1); step;
    outs("R8", 1, 8'h44, 1, 8'h45, 1, 8'h46);
    drive(1,3,1,8'h47, 1,1,3,8'h48, 1,1,0,8'h49); #1;
    chk("R8", "l_rdy", l_rdy, 0); step;
    outs("R9", 1, 8'h47, 1, 8'h48, 0, 0);
    drive(1,1,2,8'h4a, 1,1,0,8'h4b, 1,2,2,8'h4c); #1;
    chk("R8", "l_rdy", l_rdy, 1); step;
    outs("R7", 1, 8'h4c, 1, 8'h4b, 1, 8'h4a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_dim_order;
    t_wrap;
    t_contention;
    t_inject;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule